// File: doc/BRIEF.md
# Dual-clock FIFO with status flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Each side has its own reset and its own set of status outputs, so logic in either domain can pace itself without looking across the boundary. Write and read positions are kept as binary counters with one extra wrap bit. Each counter is re-encoded in Gray code before it crosses to the other domain through a chain of `SYNC_STAGES` flops.

The write side accepts a word on any `wclk` edge where `wr_en` is high and `full` is low. A request made while `full` is high is the back-pressure case: the word is discarded and `overflow` reports the drop. The read side works the same way on `rclk`. A request made while `empty` is low returns one word on `rd_data` with `data_valid`. A request made while `empty` is high is refused and reported on `underflow`. Each status output has a fixed update latency. A flag that reacts to its own side's transfer updates at once or one edge later. A flag that reacts to the far side's transfer waits for the synchronizer chain plus a few decode registers. Two occupancy thresholds are static inputs.

Top module: `dcf_flagged_fifo`

## Requirements
- R1: Words leave in the order they were accepted. Each accepted read presents its word on `rd_data` with `data_valid` high after that same `rclk` edge, for one cycle.
- R2: An accepted write raises `wr_ack` after the same `wclk` edge. `full` (occupancy equal to 2^ADDR_W) and `almost_full` (occupancy at least 2^ADDR_W-1) include that write after the same edge.
- R3: `wr_count` and `thresh_full` include a write one `wclk` edge after `wr_ack`. `thresh_full` is high while that count is at or above `full_thresh`.
- R4: A write requested while `full` is high stores nothing and leaves the write position unchanged. `overflow` is high for one cycle and `wr_ack` stays low.
- R5: An accepted read updates `empty` (occupancy zero) and `almost_empty` (occupancy at most one) after the same `rclk` edge.
- R6: `rd_count` and `thresh_empty` include a read one `rclk` edge later. `thresh_empty` is high while that count is at or below `empty_thresh`.
- R7: A read requested while `empty` is high returns no word. `underflow` is high for one cycle and the read position is unchanged.
- R8: After a read edge, `full`, `almost_full` and `wr_count` change SYNC_STAGES+2 `wclk` edges later, and `thresh_full` changes SYNC_STAGES+3 edges later. One further edge is allowed for either.
- R9: After a write edge, `rd_count` changes SYNC_STAGES+2 `rclk` edges later, `thresh_empty` SYNC_STAGES+3 edges later, and `empty` and `almost_empty` SYNC_STAGES+4 edges later. One further edge is allowed for each.
- R10: Reads never cause `wr_ack` or `overflow`. Writes never cause `data_valid` or `underflow`.
- R11: During reset, `full`, `almost_full`, `thresh_full`, `wr_ack`, `overflow`, `data_valid` and `underflow` are low. `empty`, `almost_empty` and `thresh_empty` are high, and both counts are zero.
- R12: Each position moves across domains as a Gray code with a wrap bit, changing at most one bit per edge. Order and counts stay correct after both positions wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low, asynchronous |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full_thresh | input | ADDR_W+1 | Static level for `thresh_full` |
| full | output | 1 | No free entry |
| almost_full | output | 1 | At most one free entry |
| thresh_full | output | 1 | Write-side count at or above `full_thresh` |
| wr_ack | output | 1 | Previous edge stored a word |
| overflow | output | 1 | Previous edge dropped a write |
| wr_count | output | ADDR_W+1 | Occupancy seen by the write side |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low, asynchronous |
| rd_en | input | 1 | Read request |
| empty_thresh | input | ADDR_W+1 | Static level for `thresh_empty` |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| data_valid | output | 1 | `rd_data` holds a new word |
| empty | output | 1 | No stored word |
| almost_empty | output | 1 | At most one stored word |
| thresh_empty | output | 1 | Read-side count at or below `empty_thresh` |
| underflow | output | 1 | Previous edge refused a read |
| rd_count | output | ADDR_W+1 | Occupancy seen by the read side |

## Verification
The assertions check every cycle that an accepted request is acknowledged on the next edge. They check that a refused request raises its error strobe without moving the Gray position, that each Gray position steps by at most one bit, and that the full and empty flags imply their "almost" partners. Only the bench scenarios can show the cross-domain latencies of R8 and R9, because the bench counts far-side edges from one isolated transfer until each flag moves. The same holds for the exact threshold crossings and for data order across pointer wrap.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef struct packed {
    logic full;
    logic afull;
    logic tfull;
    logic ack;
    logic ovf;
  } wr_flags_t;

  typedef struct packed {
    logic empty;
    logic aempty;
    logic tempty;
    logic valid;
    logic udf;
  } rd_flags_t;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg <= '0;
      else        stg[0] <= d;
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_gray2bin.sv
module dcf_gray2bin #(
  parameter int W = 5
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge wclk)
    if (we) cells[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= cells[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic [AW:0]   level,
  output logic [AW-1:0] waddr,
  output logic          we,
  output logic [AW:0]   wgray,
  output wr_flags_t     flags,
  output logic [AW:0]   count
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP    = PW'(1) << AW;
  localparam logic [PW-1:0] CAP_M1 = CAP - PW'(1);

  logic [PW-1:0] wbin, wbin_nxt, occ_nxt;
  logic [PW-1:0] rq_dec, rq_bin, rq_bin_d;
  logic          accept;

  dcf_gray2bin #(.W(PW)) u_dec (.g(rgray_s), .b(rq_dec));

  always_comb begin
    accept   = wr_en & ~flags.full;
    wbin_nxt = wbin + PW'(accept);
    occ_nxt  = wbin_nxt - rq_bin;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rq_bin   <= '0;
      rq_bin_d <= '0;
      flags    <= '0;
      count    <= '0;
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= wbin_nxt ^ (wbin_nxt >> 1);
      rq_bin      <= rq_dec;
      rq_bin_d    <= rq_bin;
      flags.full  <= (occ_nxt == CAP);
      flags.afull <= (occ_nxt >= CAP_M1);
      flags.ack   <= accept;
      flags.ovf   <= wr_en & flags.full;
      flags.tfull <= ((wbin - rq_bin_d) >= level);
      count       <= wbin - rq_bin;
    end

  assign waddr = wbin[AW-1:0];
  assign we    = accept;
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW:0]   wgray_s,
  input  logic [AW:0]   level,
  output logic [AW-1:0] raddr,
  output logic          re,
  output logic [AW:0]   rgray,
  output rd_flags_t     flags,
  output logic [AW:0]   count
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] rbin, rbin_nxt, occ_nxt;
  logic [PW-1:0] wq_dec, wq_bin, wq_d, wq_dd;
  logic          accept;

  dcf_gray2bin #(.W(PW)) u_dec (.g(wgray_s), .b(wq_dec));

  always_comb begin
    accept   = rd_en & ~flags.empty;
    rbin_nxt = rbin + PW'(accept);
    occ_nxt  = wq_dd - rbin_nxt;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wq_bin <= '0;
      wq_d   <= '0;
      wq_dd  <= '0;
      flags  <= '{empty: 1'b1, aempty: 1'b1, tempty: 1'b1, valid: 1'b0, udf: 1'b0};
      count  <= '0;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= rbin_nxt ^ (rbin_nxt >> 1);
      wq_bin       <= wq_dec;
      wq_d         <= wq_bin;
      wq_dd        <= wq_d;
      flags.empty  <= (occ_nxt == '0);
      flags.aempty <= (occ_nxt <= ONE);
      flags.valid  <= accept;
      flags.udf    <= rd_en & flags.empty;
      flags.tempty <= ((wq_d - rbin) <= level);
      count        <= wq_bin - rbin;
    end

  assign raddr = rbin[AW-1:0];
  assign re    = accept;
endmodule

// File: rtl/dcf_flagged_fifo.sv
module dcf_flagged_fifo
  import dcf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W:0]   full_thresh,
  output logic              full,
  output logic              almost_full,
  output logic              thresh_full,
  output logic              wr_ack,
  output logic              overflow,
  output logic [ADDR_W:0]   wr_count,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   empty_thresh,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_valid,
  output logic              empty,
  output logic              almost_empty,
  output logic              thresh_empty,
  output logic              underflow,
  output logic [ADDR_W:0]   rd_count
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_gray, rd_gray, wr_gray_s, rd_gray_s;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;
  wr_flags_t         wflags;
  rd_flags_t         rflags;

  dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk (wclk), .we (we), .waddr (waddr), .wdata (wr_data),
    .rclk (rclk), .re (re), .raddr (raddr), .rdata (rd_data)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk (wclk), .rst_n (wrst_n), .d (rd_gray), .q (rd_gray_s)
  );

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk (rclk), .rst_n (rrst_n), .d (wr_gray), .q (wr_gray_s)
  );

  dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk (wclk), .rst_n (wrst_n), .wr_en (wr_en), .rgray_s (rd_gray_s),
    .level (full_thresh), .waddr (waddr), .we (we), .wgray (wr_gray),
    .flags (wflags), .count (wr_count)
  );

  dcf_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk (rclk), .rst_n (rrst_n), .rd_en (rd_en), .wgray_s (wr_gray_s),
    .level (empty_thresh), .raddr (raddr), .re (re), .rgray (rd_gray),
    .flags (rflags), .count (rd_count)
  );

  assign full         = wflags.full;
  assign almost_full  = wflags.afull;
  assign thresh_full  = wflags.tfull;
  assign wr_ack       = wflags.ack;
  assign overflow     = wflags.ovf;
  assign empty        = rflags.empty;
  assign almost_empty = rflags.aempty;
  assign thresh_empty = rflags.tempty;
  assign data_valid   = rflags.valid;
  assign underflow    = rflags.udf;
endmodule

// File: rtl/dcf_flagged_fifo_chk.sv
module dcf_flagged_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic            wclk,
  input logic            wrst_n,
  input logic            rclk,
  input logic            rrst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic            full,
  input logic            almost_full,
  input logic            wr_ack,
  input logic            overflow,
  input logic [ADDR_W:0] wr_count,
  input logic            empty,
  input logic            almost_empty,
  input logic            data_valid,
  input logic            underflow,
  input logic [ADDR_W:0] wr_gray,
  input logic [ADDR_W:0] rd_gray
);
  localparam logic [ADDR_W:0] CAP = (ADDR_W+1)'(1) << ADDR_W;

  // R2: accepted write acknowledged on the next edge
  p_ack_on_accept_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && !full) |=> wr_ack);

  // R2: full only together with almost_full
  p_full_has_af_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> almost_full);

  // R3: write-side count never exceeds capacity
  p_count_bound_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_count <= CAP);

  // R4: refused write flagged, position frozen
  p_ovf_drop_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> (overflow && !wr_ack && $stable(wr_gray)));

  // R5: accepted read returns a word
  p_valid_on_accept_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && !empty) |=> data_valid);

  // R5: empty only together with almost_empty
  p_empty_has_ae_r5: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> almost_empty);

  // R7: refused read flagged, position frozen
  p_udf_drop_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> (underflow && !data_valid && $stable(rd_gray)));

  // R12: crossing codes move by one bit at most
  p_wgray_step_r12: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  p_rgray_step_r12: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

bind dcf_flagged_fifo dcf_flagged_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk (wclk), .wrst_n (wrst_n), .rclk (rclk), .rrst_n (rrst_n),
  .wr_en (wr_en), .rd_en (rd_en), .full (full), .almost_full (almost_full),
  .wr_ack (wr_ack), .overflow (overflow), .wr_count (wr_count),
  .empty (empty), .almost_empty (almost_empty), .data_valid (data_valid),
  .underflow (underflow), .wr_gray (wr_gray), .rd_gray (rd_gray)
);

// File: tb/dcf_flagged_fifo_test.sv
module dcf_flagged_fifo_test;
  localparam int DW = 8, AW = 4, NS = 2, CAP = 16;

  logic wclk = 0, rclk = 0;
  initial forever #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  logic          wrst_n, rrst_n, wr_en, rd_en;
  logic [DW-1:0] wr_data, rd_data;
  logic [AW:0]   full_thresh, empty_thresh, wr_count, rd_count;
  logic full, almost_full, thresh_full, wr_ack, overflow;
  logic data_valid, empty, almost_empty, thresh_empty, underflow;

  dcf_flagged_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(NS)) uut (.*);

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic win(input string tag, input int act, input int lo);
    chk(act == lo || act == lo + 1, tag, act, lo);
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge rclk); #2;
    if (rrst_n && data_valid) begin
      if (sb.size() == 0) chk(0, "R1 word with nothing pending", rd_data, -1);
      else eq("R1 read order", rd_data, sb.pop_front());
    end
  end

  task automatic wr_pulse(input logic [DW-1:0] d);
    bit acc;
    @(negedge wclk);
    acc = !full; wr_en = 1; wr_data = d;
    @(posedge wclk);
    if (acc) sb.push_back(d);
    #2 wr_en = 0;
  endtask

  task automatic rd_pulse();
    @(negedge rclk); rd_en = 1;
    @(posedge rclk); #2 rd_en = 0;
  endtask

  task automatic watch_wr(output int t_f, output int t_af, output int t_c,
                          output int t_p, output bit hit);
    logic f0, a0, p0; logic [AW:0] c0;
    f0 = full; a0 = almost_full; p0 = thresh_full; c0 = wr_count;
    t_f = 0; t_af = 0; t_c = 0; t_p = 0; hit = 0;
    for (int i = 1; i <= 12; i++) begin
      @(posedge wclk); #2;
      if (t_f == 0 && full != f0) t_f = i;
      if (t_af == 0 && almost_full != a0) t_af = i;
      if (t_c == 0 && wr_count != c0) t_c = i;
      if (t_p == 0 && thresh_full != p0) t_p = i;
      if (wr_ack || overflow) hit = 1;
    end
  endtask

  task automatic watch_rd(output int t_e, output int t_ae, output int t_c,
                          output int t_p, output bit hit);
    logic e0, a0, p0; logic [AW:0] c0;
    e0 = empty; a0 = almost_empty; p0 = thresh_empty; c0 = rd_count;
    t_e = 0; t_ae = 0; t_c = 0; t_p = 0; hit = 0;
    for (int i = 1; i <= 12; i++) begin
      @(posedge rclk); #2;
      if (t_e == 0 && empty != e0) t_e = i;
      if (t_ae == 0 && almost_empty != a0) t_ae = i;
      if (t_c == 0 && rd_count != c0) t_c = i;
      if (t_p == 0 && thresh_empty != p0) t_p = i;
      if (data_valid || underflow) hit = 1;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, b, c, d;
    bit h;
    wrst_n = 0; rrst_n = 0; wr_en = 0; rd_en = 0; wr_data = '0;
    full_thresh = 5'd12; empty_thresh = 5'd3;
    repeat (4) @(posedge wclk);
    #2;
    // R11 reset state
    eq("R11 full", full, 0); eq("R11 almost_full", almost_full, 0);
    eq("R11 thresh_full", thresh_full, 0); eq("R11 wr_ack/overflow", wr_ack | overflow, 0);
    eq("R11 empty", empty, 1); eq("R11 almost_empty", almost_empty, 1);
    eq("R11 thresh_empty", thresh_empty, 1); eq("R11 data_valid/underflow", data_valid | underflow, 0);
    eq("R11 wr_count", wr_count, 0); eq("R11 rd_count", rd_count, 0);
    @(negedge wclk) wrst_n = 1;
    @(negedge rclk) rrst_n = 1;
    repeat (3) @(posedge wclk);
    #2;

    // single write, far-side latency
    wr_pulse(8'hA5);
    eq("R2 wr_ack after write", wr_ack, 1);
    eq("R3 wr_count not yet", wr_count, 0);
    watch_rd(a, b, c, d, h);
    win("R9 empty latency", a, NS + 4);
    win("R9 rd_count latency", c, NS + 2);
    eq("R9 almost_empty held at one word", b, 0);
    eq("R10 no read strobes from write", h, 0);
    eq("R3 wr_count after write", wr_count, 1);

    // single read
    rd_pulse();
    eq("R5 data_valid", data_valid, 1);
    eq("R5 empty after last read", empty, 1);
    eq("R6 rd_count not yet", rd_count, 1);
    watch_wr(a, b, c, d, h);
    win("R8 wr_count latency", c, NS + 2);
    eq("R10 no write strobes from read", h, 0);
    eq("R6 rd_count after read", rd_count, 0);

    // fill to full
    for (int k = 1; k <= CAP; k++) begin
      @(negedge wclk);
      if (!full) sb.push_back(8'(k + 16));
      wr_en = 1; wr_data = 8'(k + 16);
      @(posedge wclk); #2;
      eq("R2 wr_ack in burst", wr_ack, 1);
      eq("R2 full in burst", full, int'(k == CAP));
      eq("R2 almost_full in burst", almost_full, int'(k >= CAP - 1));
      eq("R3 wr_count lags by one", wr_count, k - 1);
      eq("R3 thresh_full lags by one", thresh_full, int'(k - 1 >= 12));
    end
    @(negedge wclk) wr_en = 0;
    @(posedge wclk); #2;
    eq("R3 wr_count at capacity", wr_count, CAP);
    eq("R3 thresh_full at capacity", thresh_full, 1);

    // overflow
    wr_pulse(8'hEE);
    eq("R4 overflow", overflow, 1);
    eq("R4 no ack", wr_ack, 0);
    @(posedge wclk); #2;
    eq("R4 overflow one cycle", overflow, 0);
    eq("R4 count unchanged", wr_count, CAP);

    // reads seen from the write side
    for (int j = 1; j <= 5; j++) begin
      rd_pulse();
      watch_wr(a, b, c, d, h);
      win("R8 wr_count latency", c, NS + 2);
      eq("R10 no write strobes from read", h, 0);
      if (j == 1) begin win("R8 full latency", a, NS + 2); eq("R8 almost_full held", b, 0); end
      if (j == 2) win("R8 almost_full latency", b, NS + 2);
      if (j == 5) win("R8 thresh_full latency", d, NS + 3);
      if (j < 5) eq("R8 thresh_full held", d, 0);
    end

    // drain 11 words, then one refused read
    for (int k = 1; k <= 12; k++) begin
      @(negedge rclk) rd_en = 1;
      @(posedge rclk); #2;
      if (k <= 11) begin
        eq("R5 data_valid in drain", data_valid, 1);
        eq("R5 empty in drain", empty, int'(k == 11));
        eq("R5 almost_empty in drain", almost_empty, int'(k >= 10));
        eq("R6 rd_count lags by one", rd_count, 12 - k);
        eq("R6 thresh_empty lags by one", thresh_empty, int'(12 - k <= 3));
      end else begin
        eq("R7 underflow", underflow, 1);
        eq("R7 no data_valid", data_valid, 0);
        eq("R7 rd_count", rd_count, 0);
      end
    end
    @(negedge rclk) rd_en = 0;
    @(posedge rclk); #2;
    eq("R7 underflow one cycle", underflow, 0);

    // writes seen from the read side
    for (int j = 1; j <= 4; j++) begin
      wr_pulse(8'(8'h30 + j));
      watch_rd(a, b, c, d, h);
      win("R9 rd_count latency", c, NS + 2);
      eq("R10 no read strobes from write", h, 0);
      if (j == 1) win("R9 empty latency", a, NS + 4);
      if (j == 2) win("R9 almost_empty latency", b, NS + 4);
      if (j == 4) win("R9 thresh_empty latency", d, NS + 3);
      if (j < 4) eq("R9 thresh_empty held", d, 0);
    end

    // concurrent stream across pointer wrap
    fork
      begin
        int i = 0;
        while (i < 40) begin
          @(negedge wclk);
          if (!full) begin
            wr_en = 1; wr_data = 8'(8'h80 + i);
            @(posedge wclk);
            sb.push_back(wr_data);
            i++;
          end else wr_en = 0;
        end
        @(negedge wclk) wr_en = 0;
      end
      begin
        int nr = 0;
        while (nr < 44) begin
          @(negedge rclk);
          if (!empty) begin
            rd_en = 1;
            @(posedge rclk);
            nr++;
          end else rd_en = 0;
        end
        @(negedge rclk) rd_en = 0;
      end
    join
    repeat (12) @(posedge wclk);
    #2;
    eq("R12 all words returned after wrap", sb.size(), 0);
    eq("R12 empty after wrap", empty, 1);
    eq("R12 wr_count after wrap", wr_count, 0);
    eq("R12 rd_count after wrap", rd_count, 0);
    eq("R12 full after wrap", full, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule